// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes 32-bit responses coming back from audio codecs and decides where each one goes. Every response carries the 4-bit address of the codec that sent it and a flag that tells solicited answers from unsolicited events. Software may arm a single-shot immediate capture. While that capture is armed, the next response is latched into an immediate-response register and is not written to memory. Otherwise, if ring DMA is enabled, the response is stored as an 8-byte entry in a 256-entry response ring in system memory. If ring DMA is off, the response is discarded.

Each ring entry takes two 32-bit memory writes. The first carries the response word. The second carries a side word holding the codec address and the unsolicited flag. The ring write pointer is incremented before each entry is written. After every completed entry a response counter advances. The response-interrupt status bit is then set, if interrupts are enabled, when the counter has reached the software threshold or when the command ring reports it is empty. Software clears that status bit by writing one. The falling edge of the bit zeroes the counter and sends a one-cycle retrigger pulse to the command fetcher.

The response input and the memory write port are both valid/ready. The responder may hold `rsp_valid` for as long as it likes. A response is taken on a cycle where `rsp_valid` and `rsp_ready` are both high. `rsp_ready` stays low from that cycle until the memory fabric has accepted both words of the entry. The block holds `mem_req_valid`, `mem_req_addr` and `mem_req_data` steady until `mem_req_ready` is seen. All control and status pins are plain levels or one-cycle pulses.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset the write pointer is 0, `irq` is 0, `cmd_retrig` is 0, the immediate status byte is 0, `mem_req_valid` is 0 and `rsp_ready` is 1.
- R2: When the immediate-busy bit (status bit 0) is set, an accepted response is latched into `imm_resp`. Busy is cleared, the valid bit (status bit 1) is set, and the responding codec address appears in status bits 7:4. No memory write is issued and the write pointer does not move.
- R3: When immediate capture is not armed and `cfg_dma_en` is 0, an accepted response is dropped: no memory write is issued and the write pointer is unchanged.
- R4: For a ring-bound response the write pointer first advances by one modulo 256, so 255 is followed by 0. The response word is then written to `cfg_base + 8*wp` and the side word to `cfg_base + 8*wp + 4`.
- R5: The side word holds the codec address in bits 3:0 and a 1 in bit 4 for an unsolicited response. All other bits are 0.
- R6: The response word is issued first and the side word second. `rsp_ready` is low while either word is pending. Address and data stay stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R7: With `cfg_irq_en` high, `irq` rises once the entry that brings the response count equal to `cfg_threshold` has been fully written.
- R8: With `cfg_irq_en` high and `cmd_empty` high when an entry completes, `irq` rises even though the threshold has not been reached.
- R9: With `cfg_irq_en` low, completed entries never raise `irq`.
- R10: A one-cycle `wp_wr` with `wp_rst` high forces the write pointer to 0. A `wp_wr` with `wp_rst` low leaves the pointer unchanged.
- R11: A `sts_clr` pulse while `irq` is high drops `irq` on the next edge, zeroes the response count, and produces exactly one cycle of `cmd_retrig`.
- R12: `irq` is the level of the status bit and stays high until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Block can take a response |
| rsp_data | input | 32 | Response word |
| rsp_codec | input | 4 | Address of responding codec |
| rsp_unsol | input | 1 | 1 = unsolicited response |
| mem_req_valid | output | 1 | Memory write request valid |
| mem_req_ready | input | 1 | Memory fabric accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the write |
| mem_req_data | output | 32 | Write data |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_dma_en | input | 1 | Enable ring writes |
| cfg_irq_en | input | 1 | Enable setting of the interrupt status |
| cfg_threshold | input | CNT_W | Response count that raises the interrupt |
| wp_wr | input | 1 | Write strobe for the write-pointer register |
| wp_rst | input | 1 | Reset-bit value carried with `wp_wr` |
| resp_wp | output | PTR_W | Current ring write pointer |
| imm_busy_set | input | 1 | Arm immediate capture |
| imm_valid_clr | input | 1 | Clear the immediate valid bit |
| imm_status | output | 8 | Bit 0 busy, bit 1 valid, bits 7:4 codec address |
| imm_resp | output | 32 | Immediate response word |
| cmd_empty | input | 1 | Command ring is empty |
| sts_clr | input | 1 | Write-one-to-clear of the interrupt status |
| cmd_retrig | output | 1 | One-cycle retrigger to the command fetcher |
| irq | output | 1 | Response interrupt level |

## Verification
The bench steps the write pointer past 255 and checks that the next entry lands at offset 0. A design that let the pointer grow past eight bits, or that incremented after writing instead of before, would write to the wrong address. It also confirms that an armed immediate capture takes priority over the ring even when DMA is enabled; a design with that priority reversed would issue a memory write and move the pointer. After clearing the status, the bench sets a small threshold so that a counter that was not zeroed would never match and the interrupt would stay silent. The memory port is stalled throughout to expose any entry whose two words change while waiting or come out in the wrong order.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;
  typedef enum logic [1:0] {
    BEAT_IDLE = 2'd0,
    BEAT_RESP = 2'd1,
    BEAT_SIDE = 2'd2
  } beat_state_e;

  function automatic logic [31:0] make_side_word(input logic [3:0] codec, input logic unsol);
    return {27'd0, unsol, codec};
  endfunction
endpackage

// File: rtl/rsp_beat_issue.sv
module rsp_beat_issue
  import rsp_ring_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [31:0]       resp_word,
  input  logic [31:0]       side_word,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              idle,
  output logic              done
);
  localparam logic [ADDR_W-1:0] SIDE_OFS = ADDR_W'(4);

  beat_state_e       state;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       resp_q;
  logic [31:0]       side_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= BEAT_IDLE;
      addr_q <= '0;
      resp_q <= '0;
      side_q <= '0;
    end else begin
      case (state)
        BEAT_IDLE: if (start) begin
          state  <= BEAT_RESP;
          addr_q <= start_addr;
          resp_q <= resp_word;
          side_q <= side_word;
        end
        BEAT_RESP: if (mem_ready) state <= BEAT_SIDE;
        BEAT_SIDE: if (mem_ready) state <= BEAT_IDLE;
        default:   state <= BEAT_IDLE;
      endcase
    end
  end

  always_comb begin
    idle      = (state == BEAT_IDLE);
    mem_valid = !idle;
    mem_addr  = (state == BEAT_SIDE) ? addr_q + SIDE_OFS : addr_q;
    mem_data  = (state == BEAT_SIDE) ? side_q : resp_q;
    done      = (state == BEAT_SIDE) && mem_ready;
  end

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
endmodule

// File: rtl/rsp_ring_ctrl.sv
module rsp_ring_ctrl #(
  parameter int PTR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             done,
  input  logic             cmd_empty,
  input  logic [CNT_W-1:0] threshold,
  input  logic             irq_en,
  input  logic             wp_wr,
  input  logic             wp_rst,
  input  logic             sts_clr,
  output logic [PTR_W-1:0] wp,
  output logic [PTR_W-1:0] wp_next,
  output logic             sts,
  output logic             retrig
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             set_sts;
  logic             sts_n;
  logic             fall;

  always_comb begin
    wp_next = wp + PTR_W'(1);
    cnt_inc = cnt + CNT_W'(1);
    set_sts = done && irq_en && ((cnt_inc == threshold) || cmd_empty);
    sts_n   = set_sts ? 1'b1 : (sts_clr ? 1'b0 : sts);
    fall    = sts && !sts_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      cnt    <= '0;
      sts    <= 1'b0;
      retrig <= 1'b0;
    end else begin
      if (wp_wr && wp_rst) wp <= '0;
      else if (launch)     wp <= wp_next;
      if (fall)      cnt <= '0;
      else if (done) cnt <= cnt_inc;
      sts    <= sts_n;
      retrig <= fall;
    end
  end

  // R10
  wp_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_wr && wp_rst |=> wp == '0);
  // R11
  retrig_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrig |=> !retrig);
  // R12
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts && !sts_clr |=> sts);
endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
  import rsp_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  input  logic [3:0]        rsp_codec,
  input  logic              rsp_unsol,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_data,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_dma_en,
  input  logic              cfg_irq_en,
  input  logic [CNT_W-1:0]  cfg_threshold,
  input  logic              wp_wr,
  input  logic              wp_rst,
  output logic [PTR_W-1:0]  resp_wp,
  input  logic              imm_busy_set,
  input  logic              imm_valid_clr,
  output logic [7:0]        imm_status,
  output logic [31:0]       imm_resp,
  input  logic              cmd_empty,
  input  logic              sts_clr,
  output logic              cmd_retrig,
  output logic              irq
);
  localparam int ENTRY_SHIFT = 3;

  logic              accept, to_imm, to_ring;
  logic              beat_idle, beat_done;
  logic [PTR_W-1:0]  wp_next;
  logic [ADDR_W-1:0] entry_addr;
  logic              imm_busy, imm_valid;
  logic [3:0]        imm_codec;

  always_comb begin
    rsp_ready  = beat_idle;
    accept     = rsp_valid && rsp_ready;
    to_imm     = accept && imm_busy;
    to_ring    = accept && !imm_busy && cfg_dma_en;
    entry_addr = cfg_base + (ADDR_W'(wp_next) << ENTRY_SHIFT);
    imm_status = {imm_codec, 2'b00, imm_valid, imm_busy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_busy  <= 1'b0;
      imm_valid <= 1'b0;
      imm_codec <= '0;
      imm_resp  <= '0;
    end else if (to_imm) begin
      imm_busy  <= 1'b0;
      imm_valid <= 1'b1;
      imm_codec <= rsp_codec;
      imm_resp  <= rsp_data;
    end else begin
      if (imm_busy_set)  imm_busy  <= 1'b1;
      if (imm_valid_clr) imm_valid <= 1'b0;
    end
  end

  rsp_beat_issue #(.ADDR_W(ADDR_W)) issue_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (to_ring),
    .start_addr (entry_addr),
    .resp_word  (rsp_data),
    .side_word  (make_side_word(rsp_codec, rsp_unsol)),
    .mem_ready  (mem_req_ready),
    .mem_valid  (mem_req_valid),
    .mem_addr   (mem_req_addr),
    .mem_data   (mem_req_data),
    .idle       (beat_idle),
    .done       (beat_done)
  );

  rsp_ring_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (to_ring),
    .done      (beat_done),
    .cmd_empty (cmd_empty),
    .threshold (cfg_threshold),
    .irq_en    (cfg_irq_en),
    .wp_wr     (wp_wr),
    .wp_rst    (wp_rst),
    .sts_clr   (sts_clr),
    .wp        (resp_wp),
    .wp_next   (wp_next),
    .sts       (irq),
    .retrig    (cmd_retrig)
  );

  // R6
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_ready);
  // R2
  imm_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_imm |=> !mem_req_valid && $stable(resp_wp));
  // R3
  drop_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !imm_busy && !cfg_dma_en |=> !mem_req_valid);
endmodule

// File: tb/rsp_ring_writer_tb.sv
module rsp_ring_writer_tb_top;
  localparam int ADDR_W = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rsp_valid = 0, rsp_unsol = 0;
  logic [31:0] rsp_data = 0;
  logic [3:0]  rsp_codec = 0;
  logic        rsp_ready, mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_data;
  logic        cfg_dma_en = 0, cfg_irq_en = 0;
  logic [7:0]  cfg_threshold = 8'd200;
  logic        wp_wr = 0, wp_rst = 0, imm_busy_set = 0, imm_valid_clr = 0;
  logic        cmd_empty = 0, sts_clr = 0;
  logic [7:0]  resp_wp, imm_status;
  logic [31:0] imm_resp;
  logic        cmd_retrig, irq;

  rsp_ring_writer #(.ADDR_W(ADDR_W), .PTR_W(8), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_codec(rsp_codec), .rsp_unsol(rsp_unsol),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .cfg_base(BASE), .cfg_dma_en(cfg_dma_en), .cfg_irq_en(cfg_irq_en),
    .cfg_threshold(cfg_threshold), .wp_wr(wp_wr), .wp_rst(wp_rst),
    .resp_wp(resp_wp), .imm_busy_set(imm_busy_set), .imm_valid_clr(imm_valid_clr),
    .imm_status(imm_status), .imm_resp(imm_resp), .cmd_empty(cmd_empty),
    .sts_clr(sts_clr), .cmd_retrig(cmd_retrig), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int cyc = 0;
  logic [63:0] exp_q[$];

  logic       m_busy = 0, m_irq = 0;
  logic [7:0] m_wp = 0, m_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // memory fabric back-pressure
  always @(posedge clk) begin
    #1;
    cyc++;
    mem_req_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // scoreboard monitor: pops expected writes as handshakes occur
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      chk(!rsp_ready, "R6 ready low during entry", 64'(rsp_ready), 64'd0);
      if (exp_q.size() == 0) begin
        chk(0, "R3 unexpected memory write", {mem_req_addr, mem_req_data}, 64'd0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk({mem_req_addr, mem_req_data} == e, "R4/R5 entry addr,data",
            {mem_req_addr, mem_req_data}, e);
      end
    end
  end

  task automatic send(input logic [31:0] d, input logic [3:0] c, input logic u);
    logic [31:0] a;
    if (m_busy) begin
      m_busy = 0;
    end else if (cfg_dma_en) begin
      m_wp = m_wp + 8'd1;
      a = BASE + 32'(m_wp) * 32'd8;
      exp_q.push_back({a, d});
      exp_q.push_back({a + 32'd4, {27'd0, u, c}});
      m_cnt = m_cnt + 8'd1;
      if (cfg_irq_en && (m_cnt == cfg_threshold || cmd_empty)) m_irq = 1;
    end
    @(posedge clk); #1;
    rsp_valid = 1; rsp_data = d; rsp_codec = c; rsp_unsol = u;
    do @(negedge clk); while (!rsp_ready);
    @(posedge clk); #1;
    rsp_valid = 0;
    do @(negedge clk); while (!rsp_ready);
  endtask

  task automatic check_after(input string req);
    chk(exp_q.size() == 0, {req, " R6 both words issued"}, 64'(exp_q.size()), 64'd0);
    chk(resp_wp == m_wp, {req, " write pointer"}, 64'(resp_wp), 64'(m_wp));
    chk(irq == m_irq, {req, " irq level"}, 64'(irq), 64'(m_irq));
  endtask

  task automatic clear_sts();
    @(posedge clk); #1 sts_clr = 1;
    @(posedge clk); #1 sts_clr = 0;
    @(negedge clk);
    chk(irq == 0, "R11 irq cleared", 64'(irq), 64'd0);
    chk(cmd_retrig == m_irq, "R11 retrigger pulse", 64'(cmd_retrig), 64'(m_irq));
    if (m_irq) m_cnt = 0;
    m_irq = 0;
    @(negedge clk);
    chk(cmd_retrig == 0, "R11 retrigger one cycle", 64'(cmd_retrig), 64'd0);
  endtask

  task automatic reset_wp();
    @(posedge clk); #1 wp_wr = 1; wp_rst = 1;
    @(posedge clk); #1 wp_wr = 0; wp_rst = 0;
    @(negedge clk);
    m_wp = 0;
    chk(resp_wp == 0, "R10 pointer forced to zero", 64'(resp_wp), 64'd0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 64'd0, 64'd1);
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(resp_wp == 0, "R1 pointer", 64'(resp_wp), 64'd0);
    chk(irq == 0 && cmd_retrig == 0, "R1 irq/retrig", {irq, cmd_retrig}, 64'd0);
    chk(imm_status == 0, "R1 immediate status", 64'(imm_status), 64'd0);
    chk(!mem_req_valid && rsp_ready, "R1 handshake", {mem_req_valid, rsp_ready}, 64'd1);

    // R4 R5 R6 R9: ring writes with stalls, interrupts disabled, cmd ring empty
    stall_mode = 1; cfg_dma_en = 1; cmd_empty = 1;
    send(32'hCAFE_0001, 4'h2, 1'b0); check_after("R4 R9 first");
    send(32'hCAFE_0002, 4'hB, 1'b1); check_after("R5 unsolicited");
    send(32'hCAFE_0003, 4'hF, 1'b0); check_after("R6 third");
    cmd_empty = 0;

    // R2 immediate capture has priority over the ring
    @(posedge clk); #1 imm_busy_set = 1;
    @(posedge clk); #1 imm_busy_set = 0;
    @(negedge clk);
    chk(imm_status == 8'h01, "R2 busy armed", 64'(imm_status), 64'h01);
    m_busy = 1;
    send(32'h1234_5678, 4'h9, 1'b0);
    check_after("R2 no ring write");
    chk(imm_resp == 32'h1234_5678, "R2 immediate word", 64'(imm_resp), 64'h1234_5678);
    chk(imm_status == 8'h92, "R2 status valid+codec", 64'(imm_status), 64'h92);
    @(posedge clk); #1 imm_valid_clr = 1;
    @(posedge clk); #1 imm_valid_clr = 0;

    // R3 DMA disabled drops the response
    cfg_dma_en = 0;
    send(32'hDEAD_BEEF, 4'h1, 1'b1); check_after("R3 dropped");
    cfg_dma_en = 1;

    // R7 R12 threshold interrupt (count is 3 here)
    cfg_irq_en = 1; cfg_threshold = 8'd5;
    send(32'h0000_0A04, 4'h3, 1'b0); check_after("R7 below threshold");
    send(32'h0000_0A05, 4'h3, 1'b0); check_after("R7 threshold hit");
    repeat (5) @(negedge clk);
    chk(irq == 1, "R12 irq held", 64'(irq), 64'd1);

    // R11 clear zeroes the count
    clear_sts();
    cfg_threshold = 8'd2;
    send(32'h0000_0B01, 4'h4, 1'b1); check_after("R11 count after clear 1");
    send(32'h0000_0B02, 4'h4, 1'b0); check_after("R11 count after clear 2");
    clear_sts();

    // R8 command ring empty interrupt
    cfg_threshold = 8'd100; cmd_empty = 1;
    send(32'h0000_0C01, 4'h6, 1'b0); check_after("R8 cmd empty irq");
    clear_sts();
    cmd_empty = 0; cfg_irq_en = 0;

    // R10 pointer reset and plain write
    @(posedge clk); #1 wp_wr = 1; wp_rst = 0;
    @(posedge clk); #1 wp_wr = 0;
    @(negedge clk);
    chk(resp_wp == m_wp, "R10 write without reset bit", 64'(resp_wp), 64'(m_wp));
    reset_wp();
    send(32'h0000_0D01, 4'h7, 1'b0); check_after("R10 write after reset");

    // R4 wrap from 255 to 0
    stall_mode = 0;
    reset_wp();
    for (int i = 0; i < 256; i++) send(32'hE000_0000 + 32'(i), 4'(i), 1'(i >> 4));
    check_after("R4 wrap");
    chk(resp_wp == 0, "R4 pointer wrapped", 64'(resp_wp), 64'd0);

    finished = 1;
    report();
  end
endmodule